// File: doc/BRIEF.md
# Masked Alarm Match Interrupt Unit

This unit sits beside a real-time clock's counters. On every one-second update it compares the live time bytes against two programmable alarms. A match sets a sticky flag for that alarm. Two active-low interrupt pins report the flags. Alarm one looks at seconds, minutes, hours and day-or-date. Alarm two looks at minutes, hours and day-or-date, and it can only fire when the live seconds read 00.

Bit 7 of every alarm byte is a mask bit. When it is set, that field is left out of the comparison, which lets software choose how often the alarm repeats. Bit 6 of an alarm's day-or-date byte selects what bits 5:0 are compared against: the weekday or the date of the month. Software clears a flag by writing 0 to its bit.

A small control register holds the interrupt enables, a routing bit and a two-bit rate select. With routing at 1, each alarm drives its own pin. With routing at 0, the two enabled alarms share the first pin, and the second pin carries a square wave taken from one of four divided clock taps. Both pins are registered levels intended for an open-drain pad, where a low drives the pad and a high releases it.

Top module: `alarm_irq_unit`

## Requirements
- R1: A synchronous reset clears both flags, drives `irq_a_n` and `irq_b_n` high, and loads the control register with enables 0, routing 0 and rate 11. After reset, `irq_b_n` therefore follows `clk_taps[3]`.
- R2: Alarm one matches when every unmasked field equals its live value. A field is masked when bit 7 of its alarm byte is 1. Bits 6:0 of the alarm byte are compared against the whole live byte. The flag (`alarm_flags[0]`) reads 1 from the clock edge after the one that samples the strobe.
- R3: Alarm two (`alarm_flags[1]`) has no seconds field. It matches only when `now_sec` equals 8'h00 and its own unmasked fields equal their live values. With all three of its masks set, it fires once per minute.
- R4: In a day-or-date alarm byte, bit 6 = 1 compares bits 5:0 with `now_dow`, and bit 6 = 0 compares them with `now_date`.
- R5: Matches are evaluated only in a cycle where `sec_tick` is 1. A match that is present while `sec_tick` is 0 leaves the flags unchanged.
- R6: A flag stays at 1 until a cycle with `flag_we` = 1 and a 0 in its bit of `flag_wdata` (bit 0 for alarm one, bit 1 for alarm two). Writing 1 leaves the flag unchanged. If a clear and a match arrive in the same cycle, the flag is set.
- R7: With routing = 1, `irq_a_n` is low exactly when flag 1 and enable 1 are both set, and `irq_b_n` is low exactly when flag 2 and enable 2 are both set. Each pin is registered and shows the state of the previous cycle.
- R8: With routing = 0, `irq_a_n` is low when either enabled flag is set, and `irq_b_n` carries the selected clock tap, delayed by one register.
- R9: The rate select picks the tap for the square wave: 00 selects `clk_taps[0]` (1 Hz), 01 selects `clk_taps[1]` (4.096 kHz), 10 selects `clk_taps[2]` (8.192 kHz) and 11 selects `clk_taps[3]` (32.768 kHz). The control write fields are bit 0 enable 1, bit 1 enable 2, bit 2 routing, and bits 4:3 rate. A write takes effect at the edge that samples `ctl_we`.
- R10: The hours comparison includes bit 6 (12-hour mode) and bit 5 (PM or tens of hours). A 12-hour alarm byte therefore never matches a 24-hour live byte of the same numeral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle strobe for the once-per-second update |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hour | input | 8 | Live hours byte, including the mode and PM bits |
| now_dow | input | 8 | Live day of week |
| now_date | input | 8 | Live date of month, BCD |
| a1_sec | input | 8 | Alarm one seconds; bit 7 is the mask |
| a1_min | input | 8 | Alarm one minutes; bit 7 is the mask |
| a1_hour | input | 8 | Alarm one hours; bit 7 is the mask |
| a1_dd | input | 8 | Alarm one day or date; bit 7 is the mask, bit 6 is the select |
| a2_min | input | 8 | Alarm two minutes; bit 7 is the mask |
| a2_hour | input | 8 | Alarm two hours; bit 7 is the mask |
| a2_dd | input | 8 | Alarm two day or date; bit 7 is the mask, bit 6 is the select |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control data: enables, routing, rate |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Per-flag write data; 0 clears, 1 keeps |
| clk_taps | input | 4 | Divided clock levels, from slowest to fastest |
| alarm_flags | output | 2 | Sticky alarm flags |
| irq_a_n | output | 1 | First interrupt pin, active low |
| irq_b_n | output | 1 | Second interrupt pin or square wave |

## Verification
The assertions assume that `sec_tick` lasts a single cycle, that the clock taps are ordinary synchronous levels, and that every live byte has bit 7 clear, as legal BCD values do. The stimulus raises the strobe only through a task that holds it for exactly one cycle. It changes every input just after a rising edge and toggles the taps at fixed cycle periods. It loads only legal time values. Flag clears are sometimes made to coincide with a strobe, to exercise the case where the set must win.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int BYTE_W   = 8;
  localparam int MASK_BIT = BYTE_W - 1;
  localparam int DYDT_BIT = BYTE_W - 2;
  localparam int NUM_ALM  = 2;
  localparam int NUM_TAPS = 4;
  localparam int RATE_W   = $clog2(NUM_TAPS);
  localparam int CTL_W    = RATE_W + 3;

  typedef logic [BYTE_W-1:0] rbyte_t;

  typedef struct packed {
    rbyte_t sec;
    rbyte_t min;
    rbyte_t hour;
    rbyte_t dow;
    rbyte_t date;
  } live_time_t;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              route;
    logic              ie2;
    logic              ie1;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{rate: '1, route: 1'b0, ie2: 1'b0, ie1: 1'b0};
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  live_time_t now,
  input  rbyte_t     al_sec,
  input  rbyte_t     al_min,
  input  rbyte_t     al_hour,
  input  rbyte_t     al_dd,
  output logic       hit
);
  localparam int NF = 3;
  localparam int DD_W = DYDT_BIT;

  rbyte_t        al_f  [NF];
  rbyte_t        now_f [NF];
  logic [NF-1:0] f_ok;
  rbyte_t        dd_target;
  logic          dd_ok;
  logic          sec_gate;

  always_comb begin
    al_f[0]  = al_sec;  now_f[0] = now.sec;
    al_f[1]  = al_min;  now_f[1] = now.min;
    al_f[2]  = al_hour; now_f[2] = now.hour;
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign f_ok[i] = al_f[i][MASK_BIT] |
                     ({1'b0, al_f[i][MASK_BIT-1:0]} == now_f[i]);
  end

  assign dd_target = al_dd[DYDT_BIT] ? now.dow : now.date;
  assign dd_ok     = al_dd[MASK_BIT] |
                     ({{(BYTE_W-DD_W){1'b0}}, al_dd[DD_W-1:0]} == dd_target);

  if (HAS_SEC) begin : g_sec
    assign sec_gate = 1'b1;
  end else begin : g_nosec
    assign sec_gate = (now.sec == '0);
  end

  assign hit = (&f_ok) & dd_ok & sec_gate;
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags
  import alarm_pkg::*;
#(
  parameter int N = NUM_ALM
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] hit,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic set_now;
    logic clr_now;
    assign set_now = tick & hit[i];
    assign clr_now = wr_en & ~wr_data[i];
    always_ff @(posedge clk) begin
      if (rst)          flags[i] <= 1'b0;
      else if (set_now) flags[i] <= 1'b1;
      else if (clr_now) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sqw_mux.sv
module sqw_mux
  import alarm_pkg::*;
#(
  parameter int NT = NUM_TAPS,
  localparam int SW = $clog2(NT)
) (
  input  logic [NT-1:0] taps,
  input  logic [SW-1:0] sel,
  output logic          wave
);
  always_comb begin
    wave = 1'b0;
    for (int i = 0; i < NT; i++)
      if (sel == SW'(i)) wave = taps[i];
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sec_tick,
  input  logic [BYTE_W-1:0]   now_sec,
  input  logic [BYTE_W-1:0]   now_min,
  input  logic [BYTE_W-1:0]   now_hour,
  input  logic [BYTE_W-1:0]   now_dow,
  input  logic [BYTE_W-1:0]   now_date,
  input  logic [BYTE_W-1:0]   a1_sec,
  input  logic [BYTE_W-1:0]   a1_min,
  input  logic [BYTE_W-1:0]   a1_hour,
  input  logic [BYTE_W-1:0]   a1_dd,
  input  logic [BYTE_W-1:0]   a2_min,
  input  logic [BYTE_W-1:0]   a2_hour,
  input  logic [BYTE_W-1:0]   a2_dd,
  input  logic                ctl_we,
  input  logic [CTL_W-1:0]    ctl_wdata,
  input  logic                flag_we,
  input  logic [NUM_ALM-1:0]  flag_wdata,
  input  logic [NUM_TAPS-1:0] clk_taps,
  output logic [NUM_ALM-1:0]  alarm_flags,
  output logic                irq_a_n,
  output logic                irq_b_n
);
  localparam rbyte_t MASKED = rbyte_t'(1) << MASK_BIT;

  live_time_t         now_t;
  ctl_t               ctl_q;
  logic [NUM_ALM-1:0] hit;
  logic [NUM_ALM-1:0] active;
  logic               sq_wave;
  logic               ctl_route;
  logic [RATE_W-1:0]  ctl_rate;

  assign now_t = '{sec: now_sec, min: now_min, hour: now_hour,
                   dow: now_dow, date: now_date};

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= CTL_RESET;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  assign ctl_route = ctl_q.route;
  assign ctl_rate  = ctl_q.rate;

  alarm_cmp #(.HAS_SEC(1'b1)) u_cmp1 (
    .now(now_t), .al_sec(a1_sec), .al_min(a1_min),
    .al_hour(a1_hour), .al_dd(a1_dd), .hit(hit[0])
  );

  alarm_cmp #(.HAS_SEC(1'b0)) u_cmp2 (
    .now(now_t), .al_sec(MASKED), .al_min(a2_min),
    .al_hour(a2_hour), .al_dd(a2_dd), .hit(hit[1])
  );

  alarm_flags #(.N(NUM_ALM)) u_flags (
    .clk(clk), .rst(rst), .tick(sec_tick), .hit(hit),
    .wr_en(flag_we), .wr_data(flag_wdata), .flags(alarm_flags)
  );

  sqw_mux #(.NT(NUM_TAPS)) u_sqw (
    .taps(clk_taps), .sel(ctl_rate), .wave(sq_wave)
  );

  assign active = alarm_flags & {ctl_q.ie2, ctl_q.ie1};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_a_n <= 1'b1;
      irq_b_n <= 1'b1;
    end else if (ctl_route) begin
      irq_a_n <= ~active[0];
      irq_b_n <= ~active[1];
    end else begin
      irq_a_n <= ~(|active);
      irq_b_n <= sq_wave;
    end
  end
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
  import alarm_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                sec_tick,
  input logic                flag_we,
  input logic [NUM_ALM-1:0]  flag_wdata,
  input logic [NUM_TAPS-1:0] clk_taps,
  input logic [NUM_ALM-1:0]  alarm_flags,
  input logic                ctl_route,
  input logic [RATE_W-1:0]   ctl_rate,
  input logic [NUM_ALM-1:0]  hit,
  input logic                irq_a_n,
  input logic                irq_b_n
);
  // R1: state just after reset is released
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alarm_flags == '0) && irq_a_n && irq_b_n);

  // R5: a flag rises only after a strobe with a match
  a_r5_set_needs_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flags[0]) |-> $past(sec_tick && hit[0]));
  a_r5_set_needs_tick2: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flags[1]) |-> $past(sec_tick && hit[1]));

  // R6: a flag falls only after a zero write to its bit
  a_r6_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_flags[0]) |-> $past(flag_we && !flag_wdata[0]));
  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && hit[1]) |=> alarm_flags[1]);

  // R7: separate routing, alarm two pin follows its flag
  a_r7_pin_b_low: assert property (@(posedge clk) disable iff (rst)
    (ctl_route && !alarm_flags[1]) |=> irq_b_n);

  // R8: shared routing, any set flag alone cannot raise the first pin low unless enabled
  a_r8_no_flags_high: assert property (@(posedge clk) disable iff (rst)
    (alarm_flags == '0) |=> irq_a_n);

  // R9: fastest rate carries the fastest tap
  a_r9_fast_tap: assert property (@(posedge clk) disable iff (rst)
    (!ctl_route && ctl_rate == '1) |=> (irq_b_n == $past(clk_taps[NUM_TAPS-1])));
endmodule

bind alarm_irq_unit alarm_irq_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .flag_we(flag_we),
  .flag_wdata(flag_wdata), .clk_taps(clk_taps), .alarm_flags(alarm_flags),
  .ctl_route(ctl_route), .ctl_rate(ctl_rate), .hit(hit),
  .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
);

// File: tb/sim_alarm_irq_unit.sv
module sim_alarm_irq_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00;
  logic [7:0] now_dow = 8'h01, now_date = 8'h01;
  logic [7:0] a1_sec = 8'h80, a1_min = 8'h80, a1_hour = 8'h80, a1_dd = 8'h80;
  logic [7:0] a2_min = 8'h80, a2_hour = 8'h80, a2_dd = 8'h80;
  logic ctl_we = 1'b0;
  logic [4:0] ctl_wdata = 5'd0;
  logic flag_we = 1'b0;
  logic [1:0] flag_wdata = 2'b11;
  logic [3:0] clk_taps = 4'b0000;
  logic [1:0] alarm_flags;
  logic irq_a_n, irq_b_n;

  int compared = 0, mismatched = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0, done = 0;

  // reference model state
  bit mf1, mf2, m_ie1, m_ie2, m_route;
  int m_rate;
  bit exp_a, exp_b;
  bit [1:0] exp_f;

  always #2 clk = ~clk;

  alarm_irq_unit u0 (
    .clk, .rst, .sec_tick, .now_sec, .now_min, .now_hour, .now_dow, .now_date,
    .a1_sec, .a1_min, .a1_hour, .a1_dd, .a2_min, .a2_hour, .a2_dd,
    .ctl_we, .ctl_wdata, .flag_we, .flag_wdata, .clk_taps,
    .alarm_flags, .irq_a_n, .irq_b_n
  );

  function automatic bit fld_ok(int al, int live);
    if (al >= 128) return 1;
    return (al % 128) == live;
  endfunction

  function automatic bit dd_ok(int al, int dow, int date);
    int tgt;
    if (al >= 128) return 1;
    tgt = ((al / 64) % 2 == 1) ? dow : date;
    return (al % 64) == tgt;
  endfunction

  function automatic bit ref_hit1();
    return fld_ok(a1_sec, now_sec) && fld_ok(a1_min, now_min) &&
           fld_ok(a1_hour, now_hour) && dd_ok(a1_dd, now_dow, now_date);
  endfunction

  function automatic bit ref_hit2();
    return (now_sec == 0) && fld_ok(a2_min, now_min) &&
           fld_ok(a2_hour, now_hour) && dd_ok(a2_dd, now_dow, now_date);
  endfunction

  always @(posedge clk) begin
    bit h1, h2, act1, act2;
    cyc++;
    if (rst) begin
      started = 1;
      mf1 = 0; mf2 = 0; m_ie1 = 0; m_ie2 = 0; m_route = 0; m_rate = 3;
      exp_a = 1; exp_b = 1;
    end else begin
      act1 = mf1 && m_ie1;
      act2 = mf2 && m_ie2;
      if (m_route) begin
        exp_a = !act1; exp_b = !act2;
      end else begin
        exp_a = !(act1 || act2); exp_b = clk_taps[m_rate];
      end
      h1 = sec_tick && ref_hit1();
      h2 = sec_tick && ref_hit2();
      if (h1) mf1 = 1; else if (flag_we && !flag_wdata[0]) mf1 = 0;
      if (h2) mf2 = 1; else if (flag_we && !flag_wdata[1]) mf2 = 0;
      if (ctl_we) begin
        m_ie1 = ctl_wdata[0]; m_ie2 = ctl_wdata[1];
        m_route = ctl_wdata[2]; m_rate = ctl_wdata[4:3];
      end
    end
    exp_f = {mf2, mf1};
  end

  // taps: synchronous levels toggling at fixed cycle periods
  always @(posedge clk) begin
    #1;
    clk_taps[3] <= ~clk_taps[3];
    if (cyc % 3 == 0)  clk_taps[2] <= ~clk_taps[2];
    if (cyc % 7 == 0)  clk_taps[1] <= ~clk_taps[1];
    if (cyc % 40 == 0) clk_taps[0] <= ~clk_taps[0];
  end

  task automatic cmp(string what, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cmp("flags", alarm_flags, exp_f);
      cmp("irq_a_n", irq_a_n, exp_a);
      cmp("irq_b_n", irq_b_n, exp_b);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic tick_once();
    sec_tick = 1; step(); sec_tick = 0; step(2);
  endtask

  task automatic clear_flags(bit [1:0] d);
    flag_we = 1; flag_wdata = d; step(); flag_we = 0; flag_wdata = 2'b11; step(2);
  endtask

  task automatic ctl_write(bit [4:0] d);
    ctl_we = 1; ctl_wdata = d; step(); ctl_we = 0; step(3);
  endtask

  task automatic set_time(int s, int m, int h, int dw, int dt);
    now_sec = s; now_min = m; now_hour = h; now_dow = dw; now_date = dt; step();
  endtask

  initial begin
    cur_req = "R1";
    step(4); rst = 0; step(12);          // R1: reset state, pin b follows fastest tap

    cur_req = "R7"; ctl_write(5'b00111); // route separate, both enables
    cur_req = "R2";
    set_time('h30, 'h15, 'h08, 3, 'h21);
    tick_once();                          // R2: all masks set, fires every second
    clear_flags(2'b00);
    a1_sec = 8'h30; tick_once();          // R2: seconds match
    clear_flags(2'b10);
    a1_sec = 8'h31; tick_once();          // R2: seconds differ, no set
    a1_sec = 8'h30; a1_min = 8'h15; a1_hour = 8'h08; a1_dd = 8'h21;
    tick_once();                          // R2: full match on date
    clear_flags(2'b10);
    a1_min = 8'h16; tick_once();          // R2: minute mismatch

    cur_req = "R4";
    a1_min = 8'h15; a1_dd = 8'h43; tick_once();   // R4: weekday 3 matches
    clear_flags(2'b10);
    a1_dd = 8'h03; tick_once();                   // R4: date 3 vs 21, no match
    a1_dd = 8'h61; tick_once();                   // R4: weekday 0x21 vs 3, no match
    a1_dd = 8'h21; tick_once();                   // R4: date match
    clear_flags(2'b10);

    cur_req = "R10";
    a1_hour = 8'h48; tick_once();                 // R10: 12h alarm vs 24h time
    set_time('h30, 'h15, 'h48, 3, 'h21); tick_once(); // R10: same mode matches
    clear_flags(2'b10);
    a1_hour = 8'h68; tick_once();                 // R10: PM bit differs

    cur_req = "R3";
    a2_min = 8'h80; a2_hour = 8'h80; a2_dd = 8'h80;
    tick_once();                                  // R3: seconds 30, no set
    set_time('h00, 'h15, 'h48, 3, 'h21); tick_once(); // R3: once per minute
    clear_flags(2'b01);
    a2_min = 8'h15; a2_hour = 8'h48; a2_dd = 8'h43; tick_once(); // R3+R4
    clear_flags(2'b01);
    a2_hour = 8'h08; tick_once();                 // R3: hour mismatch

    cur_req = "R5";
    a2_hour = 8'h48; step(20);                    // R5: match without strobe
    clear_flags(2'b00);

    cur_req = "R6";
    tick_once(); a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
    tick_once();
    clear_flags(2'b11); step(3);                  // R6: ones keep flags
    clear_flags(2'b01); step(3);                  // R6: clears alarm two only
    flag_we = 1; flag_wdata = 2'b00; sec_tick = 1; step();  // R6: set beats clear
    flag_we = 0; flag_wdata = 2'b11; sec_tick = 0; step(4);

    cur_req = "R7";
    ctl_write(5'b00101); step(3);                 // R7: only enable 1
    ctl_write(5'b00110); step(3);                 // R7: only enable 2
    ctl_write(5'b00100); step(3);                 // R7: no enables

    cur_req = "R8";
    ctl_write(5'b11001); step(10);                // R8: shared, enable 1
    ctl_write(5'b11010); step(10);                // R8: shared, enable 2
    clear_flags(2'b00); step(6);                  // R8: flags clear, pin a high

    cur_req = "R9";
    ctl_write(5'b00000); step(100);               // R9: 1 Hz tap
    ctl_write(5'b01000); step(30);                // R9: rate 01
    ctl_write(5'b10000); step(30);                // R9: rate 10
    ctl_write(5'b11000); step(30);                // R9: rate 11

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog %s: actual hung expected finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule